// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block is the device-side read path of a memory that answers bursts synchronously. A 16-bit configuration register sets four behaviours: the number of clock edges between the start strobe and the first data word, the sense of the ready output, whether ready comes with each data word or one clock ahead of it, and the burst shape. The burst shape is continuous, or a fixed run of 8, 16 or 32 words that either wraps inside its aligned block or runs straight on. A rising edge on the address-valid input latches the start address. The engine then counts out the latency and places one word per clock on the data output. Ready goes inactive when a fixed burst ends.

The words come from an internal array, which is loaded through a plain write port. A control state machine has three states. ST_IDLE has no burst in progress. ST_LATENCY counts down the initial wait. ST_BURST presents one word per clock. These transitions are named:
- *launch*: ST_IDLE to ST_LATENCY on a strobe.
- *first word*: ST_LATENCY to ST_BURST when the wait count reaches one.
- *finish*: ST_BURST to ST_IDLE after the last word of a fixed burst.
- *abort*: ST_BURST or ST_LATENCY back to ST_LATENCY on a new strobe.

Top module: `burst_read_engine`

## Requirements
- R1: After reset, `cfg_q` reads 16'h2FC8 and `cfg_err` is 0.
- R2: A write whose length field (bits 2:0) is 000 stores bit 3 as 1, whatever was written. With any other length code, bit 3 keeps the written value.
- R3: Let E0 be the clock edge at which `adv` is sampled high after being sampled low. With wait code w in bits 13:11, the first word is registered on `rdata` at edge E0+w+2. Codes 110 and 111 behave as 101 and set `cfg_err`.
- R4: Length codes 010, 011 and 100 give bursts of 8, 16 and 32 words. After the last word, ready becomes inactive. Other non-zero codes act as continuous and set `cfg_err`.
- R5: With bit 3 set and a fixed length N, word j is read from address (start & ~(N-1)) | ((start+j) & (N-1)).
- R6: With bit 3 clear and a fixed length, word j is read from address start+j, so the burst crosses the aligned block boundary.
- R7: A continuous burst (code 000) never ends on its own. Word j is read from address (start+j) modulo the array depth.
- R8: Bit 10 set makes ready active-high. Bit 10 clear makes ready active-low.
- R9: Bit 8 set makes ready active in exactly the cycles in which a valid word is on `rdata`. Bit 8 clear makes ready active in each cycle that comes just before a valid word.
- R10: A strobe during ST_LATENCY or ST_BURST drops the current burst. It restarts the latency count at the new start address.
- R11: Ready is inactive while no burst is running and while the latency is counting, except as R9 requires in the last latency cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock; rising edge is active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_q | output | 16 | Stored configuration value |
| cfg_err | output | 1 | A reserved wait or length code is stored |
| mem_we | input | 1 | Array load enable |
| mem_waddr | input | AW | Array load address |
| mem_wdata | input | DW | Array load word |
| adv | input | 1 | Address-valid strobe; a rising edge starts a burst |
| start_addr | input | AW | Start word address, captured on the strobe |
| rdata | output | DW | Burst data word |
| rdy | output | 1 | Ready, with the sense and timing set by the configuration |

## Verification
Two things can fall in one cycle. A new strobe can arrive while a burst is still delivering words, or while the latency is still counting. Either way it meets the ongoing steps of the burst. The bench issues a strobe a few words into a 32-word burst, and another one cycle into a latency count. For each of these aborts it expects ready to go inactive for the full new latency. It then expects the new burst's words to start from the new address, with no word from the dropped burst between them.

// File: rtl/brd_pkg.sv
package brd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATENCY,
        ST_BURST
    } brd_state_e;

    localparam logic [15:0] CFG_DEFAULT = 16'h2FC8;
    localparam int WAIT_LSB   = 11;
    localparam int POL_BIT    = 10;
    localparam int TIMING_BIT = 8;
    localparam int WRAP_BIT   = 3;
    localparam int LEN_W      = 6;

    typedef struct packed {
        logic [2:0]       lat;
        logic [LEN_W-1:0] len;
        logic             wrap;
        logic             pol;
        logic             with_data;
    } brd_cfg_t;

endpackage

// File: rtl/brd_cfg_reg.sv
module brd_cfg_reg
    import brd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] q,
    output brd_cfg_t    dec,
    output logic        err
);

    logic [2:0] wait_code;
    logic       wait_bad;
    logic       len_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CFG_DEFAULT;
        end else if (we) begin
            q <= {wdata[15:WRAP_BIT+1],
                  wdata[WRAP_BIT] | (wdata[2:0] == 3'b000),
                  wdata[2:0]};
        end
    end

    always_comb begin
        wait_code     = q[WAIT_LSB+2:WAIT_LSB];
        wait_bad      = (wait_code > 3'd5);
        dec.lat       = (wait_bad ? 3'd5 : wait_code) + 3'd2;
        dec.wrap      = q[WRAP_BIT];
        dec.pol       = q[POL_BIT];
        dec.with_data = q[TIMING_BIT];
        len_bad       = 1'b0;
        unique case (q[2:0])
            3'b000:  dec.len = LEN_W'(0);
            3'b010:  dec.len = LEN_W'(8);
            3'b011:  dec.len = LEN_W'(16);
            3'b100:  dec.len = LEN_W'(32);
            default: begin
                dec.len = LEN_W'(0);
                len_bad = 1'b1;
            end
        endcase
        err = wait_bad | len_bad;
    end

endmodule

// File: rtl/brd_addr_seq.sv
module brd_addr_seq
    import brd_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0]    cur,
    input  logic [LEN_W-1:0] len,
    input  logic             wrap,
    output logic [AW-1:0]    nxt
);

    logic [AW-1:0] mask;
    logic [AW-1:0] inc;

    always_comb begin
        mask = AW'(len) - AW'(1);
        inc  = cur + AW'(1);
        if (len != '0 && wrap) begin
            nxt = (cur & ~mask) | (inc & mask);
        end else begin
            nxt = inc;
        end
    end

endmodule

// File: rtl/brd_mem.sv
module brd_mem #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
    import brd_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_q,
    output logic          cfg_err,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_waddr,
    input  logic [DW-1:0] mem_wdata,
    input  logic          adv,
    input  logic [AW-1:0] start_addr,
    output logic [DW-1:0] rdata,
    output logic          rdy
);

    brd_cfg_t         dec;
    brd_state_e       state, state_n;
    logic             adv_q;
    logic             strobe;
    logic [LEN_W-1:0] cnt, cnt_n;
    logic [LEN_W-1:0] b_len;
    logic             b_wrap;
    logic [AW-1:0]    addr, addr_n, addr_inc;
    logic [DW-1:0]    mem_rd;
    logic             act;

    brd_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q),
        .dec   (dec),
        .err   (cfg_err)
    );

    brd_addr_seq #(.AW(AW)) u_seq (
        .cur  (addr),
        .len  (b_len),
        .wrap (b_wrap),
        .nxt  (addr_inc)
    );

    brd_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr_n),
        .rdata (mem_rd)
    );

    assign strobe = adv & ~adv_q;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        addr_n  = addr;
        if (strobe) begin
            state_n = ST_LATENCY;
            cnt_n   = LEN_W'(dec.lat);
            addr_n  = start_addr;
        end else begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_LATENCY: begin
                    if (cnt == LEN_W'(1)) begin
                        state_n = ST_BURST;
                        cnt_n   = (b_len == '0) ? '0 : b_len - LEN_W'(1);
                    end else begin
                        cnt_n = cnt - LEN_W'(1);
                    end
                end
                ST_BURST: begin
                    if (b_len != '0 && cnt == '0) begin
                        state_n = ST_IDLE;
                    end else begin
                        addr_n = addr_inc;
                        cnt_n  = (b_len == '0) ? '0 : cnt - LEN_W'(1);
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            adv_q  <= 1'b0;
            cnt    <= '0;
            addr   <= '0;
            b_len  <= '0;
            b_wrap <= 1'b1;
            rdata  <= '0;
        end else begin
            state <= state_n;
            adv_q <= adv;
            cnt   <= cnt_n;
            addr  <= addr_n;
            if (strobe) begin
                b_len  <= dec.len;
                b_wrap <= dec.wrap;
            end
            if (state_n == ST_BURST) begin
                rdata <= mem_rd;
            end
        end
    end

    always_comb begin
        act = dec.with_data ? (state == ST_BURST) : (state_n == ST_BURST);
        rdy = dec.pol ? act : ~act;
    end

    logic [3:0]       chk_lat;
    logic [LEN_W-1:0] chk_beats;
    logic [AW-1:0]    chk_mask;

    assign chk_mask = AW'(b_len) - AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_lat   <= '0;
            chk_beats <= '0;
        end else begin
            if (strobe) begin
                chk_lat <= '0;
            end else if (state == ST_LATENCY) begin
                chk_lat <= chk_lat + 4'd1;
            end
            if (state == ST_BURST && state_n == ST_BURST) begin
                chk_beats <= chk_beats + LEN_W'(1);
            end else begin
                chk_beats <= '0;
            end
        end
    end

    p_cfg_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> cfg_q == CFG_DEFAULT);

    p_wrap_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[2:0] == 3'b000) |-> cfg_q[WRAP_BIT]);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATENCY && state_n == ST_BURST) |-> chk_lat == {1'b0, dec.lat} - 4'd1);

    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && b_len != '0) |-> chk_beats < b_len);

    p_wrap_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && $past(state) == ST_BURST && b_len != '0 && b_wrap
         && $past(b_len) == b_len)
        |-> ((addr ^ $past(addr)) & ~chk_mask) == '0);

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> state == ST_LATENCY);

    p_quiet_rdy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BURST && state_n != ST_BURST) |-> rdy == ~dec.pol);

endmodule

// File: tb/tb_burst_read_engine.sv
module tb_burst_read_engine;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [15:0]   cfg_wdata;
    logic [15:0]   cfg_q;
    logic          cfg_err;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic          adv;
    logic [AW-1:0] start_addr;
    logic [DW-1:0] rdata;
    logic          rdy;

    always #10 clk = ~clk;

    burst_read_engine #(.AW(AW), .DW(DW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_q      (cfg_q),
        .cfg_err    (cfg_err),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .adv        (adv),
        .start_addr (start_addr),
        .rdata      (rdata),
        .rdy        (rdy)
    );

    typedef struct {
        bit          chk_rdy;
        bit          exp_rdy;
        bit          chk_dat;
        logic [15:0] exp_dat;
        string       tag;
    } item_t;

    item_t       sbq[$];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    logic [15:0] cur_cfg = 16'h2FC8;

    function automatic logic [15:0] word_of(input logic [7:0] a);
        return {~a, a};
    endfunction

    function automatic logic [15:0] mk_cfg(input logic [2:0] w, input logic pol,
                                          input logic with_d, input logic wrap,
                                          input logic [2:0] bl);
        return {2'b00, w, pol, 1'b1, with_d, 2'b11, 2'b00, wrap, bl};
    endfunction

    function automatic bit is_valid(input int k, input int lat, input int n);
        int j;
        j = k - lat;
        return (j >= 0) && (n == 0 || j < n);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                if (it.chk_rdy) check(rdy === it.exp_rdy, it.tag, "rdy",
                                      {15'd0, rdy}, {15'd0, it.exp_rdy});
                if (it.chk_dat) check(rdata === it.exp_dat, it.tag, "rdata",
                                      rdata, it.exp_dat);
            end
        end
    end

    task automatic cfg_write(input logic [15:0] v, input string tag, input bit exp_err);
        logic [15:0] stored;
        stored = {v[15:4], v[3] | (v[2:0] == 3'b000), v[2:0]};
        @(posedge clk); #2;
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk); #2;
        cfg_we = 1'b0;
        cur_cfg = stored;
        @(negedge clk);
        check(cfg_q === stored, tag, "cfg_q", cfg_q, stored);
        check(cfg_err === exp_err, tag, "cfg_err", {15'd0, cfg_err}, {15'd0, exp_err});
    endtask

    task automatic run(input logic [7:0] a0, input int n, input string tag);
        int lat, nlen, code;
        bit wrap, early, pol;
        item_t it;
        code  = int'(cur_cfg[13:11]);
        lat   = ((code > 5) ? 5 : code) + 2;
        case (cur_cfg[2:0])
            3'b010:  nlen = 8;
            3'b011:  nlen = 16;
            3'b100:  nlen = 32;
            default: nlen = 0;
        endcase
        wrap  = cur_cfg[3];
        early = !cur_cfg[8];
        pol   = cur_cfg[10];
        @(posedge clk); #2;
        adv = 1'b1;
        start_addr = a0;
        it.chk_rdy = 0; it.exp_rdy = 0; it.chk_dat = 0; it.exp_dat = '0; it.tag = tag;
        sbq.push_back(it);
        for (int k = 0; k < n; k++) begin
            int j;
            bit act;
            logic [7:0] ea;
            j = k - lat;
            if (nlen != 0 && wrap)
                ea = (a0 & ~8'(nlen - 1)) | (8'(int'(a0) + j) & 8'(nlen - 1));
            else
                ea = 8'(int'(a0) + j);
            act = early ? is_valid(k + 1, lat, nlen) : is_valid(k, lat, nlen);
            it.chk_rdy = 1;
            it.exp_rdy = pol ? act : !act;
            it.chk_dat = is_valid(k, lat, nlen);
            it.exp_dat = word_of(ea);
            it.tag = tag;
            sbq.push_back(it);
        end
        @(posedge clk); #2;
        adv = 1'b0;
        repeat (n - 1) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; adv = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0; start_addr = '0;
        repeat (3) @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_q === 16'h2FC8, "R1", "cfg_q reset", cfg_q, 16'h2FC8);
        check(cfg_err === 1'b0, "R1", "cfg_err reset", {15'd0, cfg_err}, 16'd0);
        check(rdy === 1'b0, "R11", "rdy idle", {15'd0, rdy}, 16'd0);

        @(posedge clk); #2;
        mem_we = 1'b1;
        for (int i = 0; i < 256; i++) begin
            mem_waddr = 8'(i);
            mem_wdata = word_of(8'(i));
            @(posedge clk); #2;
        end
        mem_we = 1'b0;

        run(8'h10, 47, "R3 R7 R11");

        cfg_write(mk_cfg(3'd0, 1'b1, 1'b1, 1'b0, 3'b000), "R2", 1'b0);
        run(8'hFC, 12, "R3 R7");

        cfg_write(mk_cfg(3'd3, 1'b1, 1'b1, 1'b1, 3'b010), "R2", 1'b0);
        run(8'h0D, 16, "R4 R5");

        cfg_write(mk_cfg(3'd1, 1'b1, 1'b1, 1'b0, 3'b011), "R2", 1'b0);
        run(8'h1E, 22, "R4 R6");

        cfg_write(mk_cfg(3'd2, 1'b1, 1'b1, 1'b1, 3'b100), "R4", 1'b0);
        run(8'h45, 40, "R5");

        cfg_write(mk_cfg(3'd2, 1'b0, 1'b1, 1'b1, 3'b010), "R8", 1'b0);
        run(8'h30, 14, "R8");

        cfg_write(mk_cfg(3'd4, 1'b1, 1'b0, 1'b1, 3'b010), "R9", 1'b0);
        run(8'h52, 16, "R9");

        cfg_write(mk_cfg(3'd0, 1'b0, 1'b0, 1'b0, 3'b011), "R9", 1'b0);
        run(8'h77, 20, "R8 R9");

        cfg_write(mk_cfg(3'd6, 1'b1, 1'b1, 1'b1, 3'b010), "R3", 1'b1);
        run(8'h20, 17, "R3");

        cfg_write(mk_cfg(3'd1, 1'b1, 1'b1, 1'b1, 3'b001), "R4", 1'b1);
        run(8'h60, 43, "R4");

        cfg_write(mk_cfg(3'd3, 1'b1, 1'b1, 1'b1, 3'b100), "R10", 1'b0);
        run(8'h40, 10, "R10");
        run(8'h9A, 39, "R10");
        run(8'h11, 2, "R10");
        run(8'hC3, 39, "R10 R11");

        wait (sbq.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule